// File: doc/BRIEF.md
# Nearest-Neighbour Fractional Resampler

This block changes the rate of a sample stream by any fractional factor without doing arithmetic on the samples. Each output sample is a copy of the most recent input sample, so the block is a sample-and-hold interpolator. Input samples arrive on a data bus that is qualified by a valid flag. Output samples leave on a second data bus that has its own valid flag. An input sample arriving between two output strobes replaces the one held before it. When no input arrives between two output strobes, the held sample is sent again.

Output timing comes from a phase accumulator `PHASE_W` bits wide. Each time the accumulator advances, it adds the runtime step. A carry out of that addition marks an output sample. The step is 2^PHASE_W times the output rate, divided by the reference rate. The elaboration parameter `PACE` selects what the reference is. With `PACE_SYSCLK`, the accumulator advances on every clock and the reference is the clock rate. With `PACE_INPUT`, it advances only on input strobes and the reference is the input sample rate. The block is meant to follow an anti-alias filter and to run in a single clock domain.

The design has no state machine. Its only sequencing is the accumulator, and there are two pacing variants, chosen at elaboration rather than switched at run time. In the `PACE_SYSCLK` variant the accumulator advances on every clock. In the `PACE_INPUT` variant it advances on input strobes and holds otherwise.

Top module: `nn_resampler`

## Requirements
- R1: While `rst` is high at a clock edge, the block clears the accumulator, the held sample, `out_sample` and `out_valid`. All of them read zero in the cycle after that edge. A strobe before any input has arrived therefore outputs zero.
- R2: With `PACE_SYSCLK`, the accumulator adds `phase_step` on every clock, starting from zero after reset. `out_valid` is high in the cycle after each addition that carries out of bit PHASE_W-1. For example, with PHASE_W=8 and step 64, the first strobe follows the 4th edge, and there are 4 strobes in 16 cycles.
- R3: With `PACE_INPUT`, the accumulator adds `phase_step` only at edges where `in_valid` is high. `out_valid` is low in the cycle after any edge where `in_valid` was low.
- R4: The held sample is loaded from `in_sample` at every edge where `in_valid` is high. When several inputs arrive between two strobes, the next strobe carries the last of them.
- R5: When no input arrives between two strobes, the second strobe repeats the data of the first.
- R6: When an input and a carry occur at the same edge, `out_sample` takes the sample that was held before that edge. The new input appears only at the following strobe.
- R7: `out_sample` changes only in cycles where `out_valid` is high.
- R8: A `phase_step` of zero produces no output strobes.
- R9: A change to `phase_step` takes effect at the next accumulator addition. The accumulator keeps its phase across the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| phase_step | input | PHASE_W | Accumulator increment: 2^PHASE_W × output rate / reference rate |
| in_valid | input | 1 | Qualifies `in_sample` |
| in_sample | input | DATA_W | Input sample |
| out_valid | output | 1 | High for one cycle per output sample |
| out_sample | output | DATA_W | Output sample, valid while `out_valid` is high |

## Verification
The bench builds two copies of the block side by side, with PHASE_W=8 and DATA_W=12. One copy uses each pacing variant, and both copies receive the same stimulus. The narrow accumulator makes exact strobe positions easy to predict: steps of 64 and 128 give strobes every 4th and every 2nd advance. A step of 200 makes the accumulator wrap with a remainder, which exercises irregular strobe spacing within a few hundred cycles. Sharing the stimulus lets a single input pattern show both clock-paced and input-paced strobes, and shows same-edge collisions in each variant.

// File: rtl/nnr_pkg.sv
package nnr_pkg;
    typedef enum logic {
        PACE_SYSCLK = 1'b0,
        PACE_INPUT  = 1'b1
    } pace_e;
endpackage

// File: rtl/nnr_phase_acc.sv
module nnr_phase_acc
    import nnr_pkg::*;
#(
    parameter int    PHASE_W = 32,
    parameter pace_e PACE    = PACE_SYSCLK
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [PHASE_W-1:0] phase_step,
    input  logic               in_valid,
    output logic               fire
);
    localparam int SUM_W = PHASE_W + 1;

    logic [PHASE_W-1:0] acc_q;
    logic [SUM_W-1:0]   sum;
    logic               advance;

    generate
        if (PACE == PACE_INPUT) begin : g_input_paced
            assign advance = in_valid;
        end else begin : g_clock_paced
            assign advance = 1'b1;
        end
    endgenerate

    always_comb begin
        sum  = {1'b0, acc_q} + {1'b0, phase_step};
        fire = advance & sum[SUM_W-1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else if (advance) begin
            acc_q <= sum[PHASE_W-1:0];
        end
    end

    // R8: a zero step never carries
    a_r8_zero_step_quiet: assert property (@(posedge clk) disable iff (rst)
        (phase_step == '0) |-> !fire);

    // R3: accumulator frozen without an input strobe in input-paced mode
    a_r3_acc_frozen: assert property (@(posedge clk) disable iff (rst)
        (PACE == PACE_INPUT && !in_valid) |=> $stable(acc_q));
endmodule

// File: rtl/nnr_sample_hold.sv
module nnr_sample_hold #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_sample,
    output logic [DATA_W-1:0] held
);
    always_ff @(posedge clk) begin
        if (rst) begin
            held <= '0;
        end else if (in_valid) begin
            held <= in_sample;
        end
    end

    // R4: every strobed input is captured
    a_r4_capture_latest: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (held == $past(in_sample)));
endmodule

// File: rtl/nnr_out_reg.sv
module nnr_out_reg #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fire,
    input  logic [DATA_W-1:0] held,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_sample
);
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            out_sample <= '0;
        end else begin
            out_valid <= fire;
            if (fire) begin
                out_sample <= held;
            end
        end
    end

    // R7: output data moves only alongside a strobe
    a_r7_data_stable: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> $stable(out_sample));
endmodule

// File: rtl/nn_resampler.sv
module nn_resampler
    import nnr_pkg::*;
#(
    parameter int    PHASE_W = 32,
    parameter int    DATA_W  = 16,
    parameter pace_e PACE    = PACE_SYSCLK
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [PHASE_W-1:0] phase_step,
    input  logic               in_valid,
    input  logic [DATA_W-1:0]  in_sample,
    output logic               out_valid,
    output logic [DATA_W-1:0]  out_sample
);
    logic              fire;
    logic [DATA_W-1:0] held;

    nnr_phase_acc #(
        .PHASE_W (PHASE_W),
        .PACE    (PACE)
    ) u_acc (
        .clk        (clk),
        .rst        (rst),
        .phase_step (phase_step),
        .in_valid   (in_valid),
        .fire       (fire)
    );

    nnr_sample_hold #(
        .DATA_W (DATA_W)
    ) u_hold (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_sample (in_sample),
        .held      (held)
    );

    nnr_out_reg #(
        .DATA_W (DATA_W)
    ) u_out (
        .clk        (clk),
        .rst        (rst),
        .fire       (fire),
        .held       (held),
        .out_valid  (out_valid),
        .out_sample (out_sample)
    );

    // R6: a colliding input does not reach the same strobe
    a_r6_old_on_collision: assert property (@(posedge clk) disable iff (rst)
        (fire && in_valid) |=> (out_sample == $past(held)));

    // R3: no strobe follows an idle input cycle when input-paced
    a_r3_idle_no_strobe: assert property (@(posedge clk) disable iff (rst)
        (PACE == PACE_INPUT && !in_valid) |=> !out_valid);
endmodule

// File: tb/test_nn_resampler.sv
module test_nn_resampler;
    import nnr_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int PW = 8;
    localparam int DW = 12;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [PW-1:0] phase_step = '0;
    logic          in_valid = 1'b0;
    logic [DW-1:0] in_sample = '0;
    logic          ov_s, ov_i;
    logic [DW-1:0] od_s, od_i;

    int nvec = 0;
    int nfail = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nn_resampler #(.PHASE_W(PW), .DATA_W(DW), .PACE(PACE_SYSCLK)) i_nn_resampler (
        .clk(clk), .rst(rst), .phase_step(phase_step), .in_valid(in_valid),
        .in_sample(in_sample), .out_valid(ov_s), .out_sample(od_s));

    nn_resampler #(.PHASE_W(PW), .DATA_W(DW), .PACE(PACE_INPUT)) i_nn_resampler_in (
        .clk(clk), .rst(rst), .phase_step(phase_step), .in_valid(in_valid),
        .in_sample(in_sample), .out_valid(ov_i), .out_sample(od_i));

    // reference behaviour from the requirements
    logic [PW-1:0] m_acc_s, m_acc_i;
    logic [DW-1:0] m_hold, m_dat_s, m_dat_i;
    logic          m_vld_s, m_vld_i;
    always @(posedge clk) begin
        logic [PW:0] s;
        if (rst) begin
            m_acc_s = '0; m_acc_i = '0; m_hold = '0;
            m_dat_s = '0; m_dat_i = '0; m_vld_s = 1'b0; m_vld_i = 1'b0;
        end else begin
            s = {1'b0, m_acc_s} + {1'b0, phase_step};
            m_vld_s = s[PW];
            if (s[PW]) m_dat_s = m_hold;
            m_acc_s = s[PW-1:0];
            if (in_valid) begin
                s = {1'b0, m_acc_i} + {1'b0, phase_step};
                m_vld_i = s[PW];
                if (s[PW]) m_dat_i = m_hold;
                m_acc_i = s[PW-1:0];
                m_hold = in_sample;
            end else begin
                m_vld_i = 1'b0;
            end
        end
    end

    task automatic expect_eq(input string req, input string what, input int act, input int exp);
        nvec++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic check_model(input string req);
        expect_eq(req, "sys valid", int'(ov_s), int'(m_vld_s));
        expect_eq(req, "sys data", int'(od_s), int'(m_dat_s));
        expect_eq(req, "inp valid", int'(ov_i), int'(m_vld_i));
        expect_eq(req, "inp data", int'(od_i), int'(m_dat_i));
    endtask

    task automatic cyc(input logic v, input logic [DW-1:0] d, input string req);
        in_valid = v;
        in_sample = d;
        @(posedge clk);
        @(negedge clk);
        check_model(req);
    endtask

    task automatic do_reset(input logic [PW-1:0] st);
        rst = 1'b1; in_valid = 1'b0; phase_step = st;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset;
        do_reset(8'd64);
        expect_eq("R1", "sys valid after reset", int'(ov_s), 0);
        expect_eq("R1", "sys data after reset", int'(od_s), 0);
        expect_eq("R1", "inp valid after reset", int'(ov_i), 0);
        for (int k = 0; k < 4; k++) cyc(1'b0, '0, "R1");
        expect_eq("R1", "first strobe data with no input", int'(od_s), 0);
        expect_eq("R1", "first strobe present", int'(ov_s), 1);
    endtask

    task automatic t_sys_rate;
        int cnt = 0;
        int first = -1;
        do_reset(8'd64);
        for (int k = 1; k <= 16; k++) begin
            cyc(1'b0, '0, "R2");
            if (ov_s) begin
                cnt++;
                if (first < 0) first = k;
            end
        end
        expect_eq("R2", "strobes in 16 cycles", cnt, 4);
        expect_eq("R2", "first strobe cycle", first, 4);
    endtask

    task automatic t_hold_latest;
        do_reset(8'd64);
        for (int k = 1; k <= 4; k++) cyc(1'b1, DW'(k * 5), "R4");
        for (int k = 1; k <= 4; k++) cyc(1'b0, '0, "R4");
        expect_eq("R4", "strobe data is latest input", int'(od_s), 20);
        for (int k = 1; k <= 4; k++) cyc(1'b0, '0, "R5");
        expect_eq("R5", "repeat strobe valid", int'(ov_s), 1);
        expect_eq("R5", "repeat strobe data", int'(od_s), 20);
    endtask

    task automatic t_input_mode;
        int bad = 0;
        int cnt = 0;
        do_reset(8'd128);
        for (int k = 0; k < 40; k++) begin
            logic v;
            v = (k % 3) != 1;
            cyc(v, DW'(100 + k), "R3");
            if (!v && ov_i) bad++;
            if (ov_i) cnt++;
        end
        expect_eq("R3", "strobe after idle input", bad, 0);
        expect_eq("R3", "input-paced strobes", cnt, 13);
    endtask

    task automatic t_collision;
        do_reset(8'd64);
        cyc(1'b1, 12'hA, "R6");
        cyc(1'b0, '0, "R6");
        cyc(1'b0, '0, "R6");
        cyc(1'b1, 12'hB, "R6");
        expect_eq("R6", "collision strobe", int'(ov_s), 1);
        expect_eq("R6", "collision takes old sample", int'(od_s), 12'hA);
        for (int k = 0; k < 3; k++) begin
            cyc(1'b0, '0, "R7");
            expect_eq("R7", "data held between strobes", int'(od_s), 12'hA);
        end
        cyc(1'b0, '0, "R6");
        expect_eq("R6", "new sample at next strobe", int'(od_s), 12'hB);
    endtask

    task automatic t_zero_step;
        int cnt = 0;
        do_reset(8'd0);
        for (int k = 0; k < 30; k++) begin
            cyc(1'b1, DW'(k), "R8");
            if (ov_s || ov_i) cnt++;
        end
        expect_eq("R8", "strobes with zero step", cnt, 0);
    endtask

    task automatic t_step_change;
        int cnt = 0;
        do_reset(8'd64);
        cyc(1'b0, '0, "R9");
        cyc(1'b0, '0, "R9");
        phase_step = 8'd200;
        cyc(1'b0, '0, "R9");
        expect_eq("R9", "carry right after change", int'(ov_s), 1);
        for (int k = 0; k < 100; k++) begin
            cyc(k % 2 == 0, DW'(k), "R9");
            if (ov_s) cnt++;
        end
        expect_eq("R9", "strobes at step 200", cnt, 78);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            nfail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_sys_rate();
        t_hold_latest();
        t_input_mode();
        t_collision();
        t_zero_step();
        t_step_change();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule